// File: doc/BRIEF.md
# Character LCD Command Interface

This block sits between a simple client and an 8-bit parallel character display. The client asks for one operation at a time over a four-phase strobe/ready handshake. It chooses one of four operations with a 2-bit code: put a character, clear, step back one position, or return the cursor home. The block turns each request into a single write cycle on the display bus, with register-select, enable and data lines driven from flip-flops. It then counts out the time the display needs to execute that instruction before it signals that it is free again.

After reset the block sets up the display on its own, before it accepts any request. It sends a clear, then selects an 8-bit single-line configuration, then turns the display on with no cursor, then sets an auto-incrementing entry mode. The strobe may come from a clock domain unrelated to the block's own. It is brought in through a synchronizer, and only its rising edge starts a transaction. The block is meant for a slow clock of about 100 kHz, so wait times are expressed in clock cycles.

Top module: `lcd_cmd_if`

## Requirements
- R1: While reset is high and directly after it, ready is 0 and lcd_e is 0.
- R2: After reset, four instructions with lcd_rs=0 are written in this order: 0x01, 0x30, 0x0C, 0x06. Ready rises exactly 4*4 + LONG_WAIT + 3*SHORT_WAIT cycles after the first clock edge with reset low.
- R3: Operation codes map as follows. 2'b00 writes lcd_rs=1 with char_code on lcd_db. 2'b01 writes lcd_rs=0 with 0x01. 2'b10 writes lcd_rs=0 with 0x10. 2'b11 writes lcd_rs=0 with 0x02.
- R4: A rising strobe, seen while ready is high, drops ready exactly three clock edges after strobe rises ahead of an edge. The code and character are taken at that point.
- R5: Each write raises lcd_e for exactly one clock cycle, and lcd_e is never high while ready is high.
- R6: lcd_rs and lcd_db hold the same value in the cycle before, the cycle during and the cycle after lcd_e is high.
- R7: Ready stays low for LONG_WAIT+3 cycles after a clear or home request, and for SHORT_WAIT+3 cycles after a character or backspace request.
- R8: A strobe rising edge detected while ready is low starts nothing. A strobe still held high when ready rises also starts nothing.
- R9: lcd_rw is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (about 100 kHz) |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Request strobe, may be asynchronous |
| op | input | 2 | Operation code, held while strobe is high |
| char_code | input | 8 | Character byte for operation 2'b00 |
| ready | output | 1 | High when a new request may begin |
| lcd_rs | output | 1 | Display register select (1 = data) |
| lcd_rw | output | 1 | Display read/write, tied to write |
| lcd_e | output | 1 | Display enable pulse |
| lcd_db | output | 8 | Display data bus |

## Verification
Two events can fall in the same cycle: the synchronized strobe edge arriving, and the wait counter expiring so that ready rises. The bench re-raises strobe during a busy period at every offset from one cycle after ready falls to past its rise. The offsets therefore include the one where the edge is detected in the last busy cycle and the first one where it is detected with ready already high. Each offset is judged by counting enable pulses, one or two, against the count the bench computes from the synchronizer latency and SHORT_WAIT.

// File: rtl/lcd_if_pkg.sv
package lcd_if_pkg;

  typedef enum logic [1:0] {
    OP_CHAR  = 2'b00,
    OP_CLEAR = 2'b01,
    OP_BKSP  = 2'b10,
    OP_HOME  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    PH_INIT,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_WAIT,
    PH_IDLE
  } phase_e;

  localparam int INIT_LEN = 4;

  // power-up instructions, issued in index order
  function automatic logic [7:0] init_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h01;
      2'd1:    return 8'h30;
      2'd2:    return 8'h0C;
      default: return 8'h06;
    endcase
  endfunction

  function automatic logic [7:0] op_byte(input op_e op, input logic [7:0] ch);
    case (op)
      OP_CHAR:  return ch;
      OP_CLEAR: return 8'h01;
      OP_BKSP:  return 8'h10;
      default:  return 8'h02;
    endcase
  endfunction

  // clear and home need the long execution time
  function automatic logic needs_long(input logic rs, input logic [7:0] b);
    return !rs && (b == 8'h01 || b == 8'h02);
  endfunction

endpackage

// File: rtl/lcd_strobe_edge.sv
module lcd_strobe_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
  parameter int MAX_COUNT = 160,
  localparam int CW = $clog2(MAX_COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(MAX_COUNT));

endmodule

// File: rtl/lcd_cmd_if.sv
module lcd_cmd_if
  import lcd_if_pkg::*;
#(
  parameter int SHORT_WAIT  = 4,
  parameter int LONG_WAIT   = 160,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(LONG_WAIT + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe,
  input  logic [1:0] op,
  input  logic [7:0] char_code,
  output logic       ready,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_db
);
  phase_e      phase_q;
  logic [1:0]  init_idx_q;
  logic        in_init_q;
  logic        rs_q, e_q, ready_q;
  logic [7:0]  db_q;
  logic        strobe_rise, timer_load, timer_done;
  logic [CW-1:0] wait_val;

  lcd_strobe_edge #(.STAGES(SYNC_STAGES)) i_edge (
    .clk(clk), .rst(rst), .async_in(strobe), .rise(strobe_rise)
  );

  assign timer_load = (phase_q == PH_HOLD);
  assign wait_val   = needs_long(rs_q, db_q) ? CW'(LONG_WAIT - 1)
                                             : CW'(SHORT_WAIT - 1);

  lcd_wait_timer #(.MAX_COUNT(LONG_WAIT)) i_timer (
    .clk(clk), .rst(rst), .load(timer_load), .load_val(wait_val),
    .expired(timer_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_INIT;
      init_idx_q <= '0;
      in_init_q  <= 1'b1;
      rs_q       <= 1'b0;
      db_q       <= '0;
      e_q        <= 1'b0;
      ready_q    <= 1'b0;
    end else begin
      case (phase_q)
        PH_INIT: begin
          rs_q    <= 1'b0;
          db_q    <= init_byte(init_idx_q);
          phase_q <= PH_SETUP;
        end
        PH_SETUP: begin
          e_q     <= 1'b1;
          phase_q <= PH_PULSE;
        end
        PH_PULSE: begin
          e_q     <= 1'b0;
          phase_q <= PH_HOLD;
        end
        PH_HOLD: phase_q <= PH_WAIT;
        PH_WAIT: begin
          if (timer_done) begin
            if (in_init_q && init_idx_q != 2'(INIT_LEN - 1)) begin
              init_idx_q <= init_idx_q + 1'b1;
              phase_q    <= PH_INIT;
            end else begin
              in_init_q <= 1'b0;
              ready_q   <= 1'b1;
              phase_q   <= PH_IDLE;
            end
          end
        end
        PH_IDLE: begin
          if (strobe_rise) begin
            rs_q    <= (op_e'(op) == OP_CHAR);
            db_q    <= op_byte(op_e'(op), char_code);
            ready_q <= 1'b0;
            phase_q <= PH_SETUP;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign ready  = ready_q;
  assign lcd_rs = rs_q;
  assign lcd_db = db_q;
  assign lcd_e  = e_q;
  assign lcd_rw = 1'b0;

  // R5
  e_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    e_q |=> !e_q);

  // R5
  e_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    e_q |-> !ready_q);

  // R6
  setup_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(e_q) |-> $stable(rs_q) && $stable(db_q));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(e_q) |-> $stable(rs_q) && $stable(db_q));

  // R8
  busy_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready_q && phase_q != PH_WAIT) |=> !ready_q);

endmodule

// File: tb/test_lcd_cmd_if.sv
module test_lcd_cmd_if;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT = 4;
  localparam int LONG  = 160;

  logic clk = 0, rst = 1, strobe = 0;
  logic [1:0] op = 0;
  logic [7:0] char_code = 0;
  logic ready, lcd_rs, lcd_rw, lcd_e;
  logic [7:0] lcd_db;

  int checks = 0, failures = 0, pulses = 0, cycles = 0;
  logic cap_rs, prev_rs, hold_pend = 0, rw_bad = 0;
  logic [7:0] cap_db, prev_db;
  logic [8:0] log_q [0:3];

  lcd_cmd_if #(.SHORT_WAIT(SHORT), .LONG_WAIT(LONG)) i_lcd_cmd_if (
    .clk(clk), .rst(rst), .strobe(strobe), .op(op), .char_code(char_code),
    .ready(ready), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
    .lcd_db(lcd_db)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor: R6 setup/hold, R5 pulse capture, R9
  always @(negedge clk) begin
    cycles++;
    if (lcd_rw !== 1'b0) rw_bad = 1;
    if (!rst) begin
      if (hold_pend) begin
        chk({lcd_rs, lcd_db} == {cap_rs, cap_db}, "R6 hold", {lcd_rs, lcd_db}, {cap_rs, cap_db});
        hold_pend = 0;
      end
      if (lcd_e) begin
        chk({lcd_rs, lcd_db} == {prev_rs, prev_db}, "R6 setup", {lcd_rs, lcd_db}, {prev_rs, prev_db});
        if (pulses < 4) log_q[pulses] = {lcd_rs, lcd_db};
        pulses++;
        cap_rs = lcd_rs; cap_db = lcd_db; hold_pend = 1;
      end
    end
    prev_rs = lcd_rs; prev_db = lcd_db;
  end

  initial begin
    wait (cycles > 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic wait_ready();
    while (ready !== 1'b1) @(negedge clk);
  endtask

  // one request; returns ready-low length
  task automatic transact(input logic [1:0] o, input logic [7:0] c, input logic exp_rs,
                          input logic [7:0] exp_db, input int exp_low);
    int base, low, lat;
    wait_ready();
    base = pulses;
    @(negedge clk); op = o; char_code = c; strobe = 1; lat = 0;
    while (ready) begin @(negedge clk); lat++; end
    strobe = 0; low = 1;
    chk(lat == 3, "R4 latency", lat, 3);
    @(negedge clk);
    while (!ready) begin low++; @(negedge clk); end
    chk(low == exp_low, "R7 busy length", low, exp_low);
    chk(pulses - base == 1, "R5 pulse count", pulses - base, 1);
    chk({cap_rs, cap_db} == {exp_rs, exp_db}, "R3 bus value", {cap_rs, cap_db}, {exp_rs, exp_db});
  endtask

  task automatic sweep(input int d);
    int base, expn;
    wait_ready();
    base = pulses;
    @(negedge clk); op = 2'b00; char_code = 8'h41; strobe = 1;
    while (ready) @(negedge clk);
    strobe = 0;
    repeat (d) @(negedge clk);
    strobe = 1;
    repeat (SHORT + 8) @(negedge clk);
    strobe = 0;
    wait_ready();
    repeat (4) @(negedge clk);
    expn = (d >= SHORT + 1) ? 2 : 1;
    chk(pulses - base == expn, "R8 edge vs busy", pulses - base, expn);
    chk(ready == 1'b1, "R8 ready after", ready, 1);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(ready == 0 && lcd_e == 0, "R1 reset state", {ready, lcd_e}, 0);
    rst = 0; n = 0;
    while (!ready) begin @(negedge clk); n++; end
    chk(n == 16 + LONG + 3 * SHORT, "R2 init length", n, 16 + LONG + 3 * SHORT);
    chk(pulses == 4, "R2 init pulses", pulses, 4);
    chk(log_q[0] == 9'h001, "R2 init 0", log_q[0], 9'h001);
    chk(log_q[1] == 9'h030, "R2 init 1", log_q[1], 9'h030);
    chk(log_q[2] == 9'h00C, "R2 init 2", log_q[2], 9'h00C);
    chk(log_q[3] == 9'h006, "R2 init 3", log_q[3], 9'h006);
    // R3 R7: every character byte
    for (int c = 0; c < 256; c++)
      transact(2'b00, 8'(c), 1'b1, 8'(c), SHORT + 3);
    for (int k = 0; k < 2; k++) begin
      transact(2'b01, 8'h5A, 1'b0, 8'h01, LONG + 3);
      transact(2'b10, 8'h5A, 1'b0, 8'h10, SHORT + 3);
      transact(2'b11, 8'hA5, 1'b0, 8'h02, LONG + 3);
    end
    // R8: re-raised strobe at each offset across the busy window
    for (int d = 1; d <= SHORT + 3; d++) sweep(d);
    chk(rw_bad == 0, "R9 rw low", rw_bad, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule